// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Booth Array and Operand-Side Sticky Prediction

The block multiplies two IEEE 754 single-precision words. Each word has 1 sign bit, an 8-bit biased exponent and a 23-bit fraction. The block returns a single-precision product and two exception flags, one for overflow and one for underflow. The operands are captured in an input register when the input strobe is high. The product is registered at the output, so `out_valid` goes high two clock cycles after `in_valid`. A new operand pair may be presented on every cycle.

The sign and exponent path is separate from the mantissa path.

- **Sign and exponent path.** Each operand is placed in one of four operand classes: CLS_ZERO (also used for subnormals, which are flushed), CLS_NORM, CLS_INF and CLS_NAN. The pair of classes selects one of four result kinds: RES_NORMAL, RES_ZERO, RES_INF and RES_QNAN. This path also forms the pre-normalization exponent.
- **Mantissa path.** The two 24-bit mantissas, hidden bit included, are multiplied by a radix-4 Booth recoder. It produces 12 signed partial-product rows and one hidden-bit correction row. These rows are reduced in a linear carry-save chain and resolved by one carry-propagate adder. Only the upper product bits leave the adder.
- **Sticky bit.** The sticky bit is not taken from the low product bits. It is predicted from the trailing-zero counts of the two mantissas, in parallel with the array.

Rounding is round-to-nearest-even. It is followed by renormalization when the round carries out of the mantissa.

The block has no stateful control beyond the two pipeline registers. The result kind selects the output format on each cycle: RES_NORMAL uses the rounded value, or infinity on overflow, or zero on underflow. RES_ZERO gives a signed zero. RES_INF gives a signed infinity. RES_QNAN gives the canonical quiet NaN.

Top module: `fpm_mul`

## Requirements
- R1: For two normal operands the result equals the exact product of the significands, rounded to nearest with ties to even, with biased exponent ea+eb-127 adjusted by normalization.
- R2: The sign bit (bit 31) of every non-NaN result is the XOR of the two operand sign bits.
- R3: When the final biased exponent is 255 or more, the result is infinity (exponent field 0xFF, fraction 0) with the operand-derived sign, and `out_overflow` is 1.
- R4: When the final biased exponent is 0 or less, the result is a zero (bits 30:0 all 0) with the operand-derived sign, and `out_underflow` is 1. A final exponent of exactly 1 gives a normal result with no flag.
- R5: An operand whose exponent field is 0 (zero or subnormal) gives a signed zero with both flags 0, unless the other operand is an infinity or NaN.
- R6: A NaN operand (exponent 0xFF with a nonzero fraction), or infinity times zero, gives 0x7FC00000. Infinity times a normal or infinite operand gives a signed infinity. Both flags are 0 in all these cases.
- R7: `out_valid` equals `in_valid` from two cycles earlier, on every cycle, including back-to-back and gapped strobes.
- R8: If rounding carries out of the mantissa, the result has fraction 0 and the exponent is incremented. Overflow is judged after this increment.
- R9: While reset is active, `out_valid`, `out_result`, `out_overflow` and `out_underflow` are all 0.
- R10: `out_overflow` and `out_underflow` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair strobe |
| in_a | input | 32 | First operand, single-precision |
| in_b | input | 32 | Second operand, single-precision |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_result | output | 32 | Single-precision product |
| out_overflow | output | 1 | Result overflowed to infinity |
| out_underflow | output | 1 | Result underflowed to zero |

## Verification
The latency properties assume that `in_valid` is held low while reset is active. The bench does this, and it drives the inputs only at falling edges so that each operand pair is sampled exactly once. The zero-operand property applies only when the other operand's exponent field is not all ones; NaN and infinity combinations are covered by separate properties. The sign property excludes results that carry the NaN pattern, whose sign is fixed at 0. The stimulus mixes directed boundary pairs with operands drawn from a mid-range exponent band and from the full exponent range, so that the overflow, underflow, tie and carry-out cases all occur.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } op_class_t;

    typedef enum logic [1:0] {
        RES_NORMAL,
        RES_ZERO,
        RES_INF,
        RES_QNAN
    } res_kind_t;

endpackage

// File: rtl/fpm_booth_array.sv
// Radix-4 Booth multiplier for unsigned MW-bit mantissas.
// The MW/2 Booth rows treat the multiplier as signed, so one correction row
// adds mcand << MW when the multiplier MSB is set. The rows are reduced by a
// carry-save chain. Only the product bits from position MW-2 upward are
// produced; the carry from the lower bits is formed by a separate chain.
module fpm_booth_array #(
    parameter int MW = 24
) (
    input  logic [MW-1:0] mcand,
    input  logic [MW-1:0] mplier,
    output logic [MW+1:0] prod_top
);
    localparam int PW   = 2 * MW;
    localparam int ROWS = MW / 2;
    localparam int LOW  = MW - 2;

    logic [PW-1:0] pp    [ROWS+1];
    logic [PW-1:0] s_acc [ROWS+2];
    logic [PW-1:0] c_acc [ROWS+2];
    logic [MW:0]   mx;
    logic [PW-1:0] a1;

    assign mx = {mplier, 1'b0};
    assign a1 = PW'(mcand);

    for (genvar r = 0; r < ROWS; r++) begin : gen_row
        logic [2:0]    grp;
        logic [PW-1:0] mag;
        assign grp = mx[2*r+2 : 2*r];
        always_comb begin
            unique case (grp)
                3'b000, 3'b111: mag = '0;
                3'b001, 3'b010: mag = a1;
                3'b011:         mag = a1 << 1;
                3'b100:         mag = ~(a1 << 1) + PW'(1);
                default:        mag = ~a1 + PW'(1);
            endcase
        end
        assign pp[r] = mag << (2 * r);
    end

    assign pp[ROWS] = mplier[MW-1] ? (a1 << MW) : '0;

    assign s_acc[0] = '0;
    assign c_acc[0] = '0;
    for (genvar i = 0; i <= ROWS; i++) begin : gen_csa
        assign s_acc[i+1] = s_acc[i] ^ c_acc[i] ^ pp[i];
        assign c_acc[i+1] = ((s_acc[i] & c_acc[i]) | (s_acc[i] & pp[i]) |
                             (c_acc[i] & pp[i])) << 1;
    end

    logic low_cy;
    always_comb begin
        low_cy = 1'b0;
        for (int k = 0; k < LOW; k++) begin
            low_cy = (s_acc[ROWS+1][k] & c_acc[ROWS+1][k]) |
                     (low_cy & (s_acc[ROWS+1][k] ^ c_acc[ROWS+1][k]));
        end
    end

    assign prod_top = s_acc[ROWS+1][PW-1:LOW] + c_acc[ROWS+1][PW-1:LOW] +
                      (MW+2)'(low_cy);

endmodule

// File: rtl/fpm_tz_sticky.sv
// Predicts the sticky bit from the mantissa trailing-zero counts. The number
// of trailing zeros of a product is the sum of the counts of its factors.
module fpm_tz_sticky #(
    parameter int MW = 24
) (
    input  logic [MW-1:0] ma,
    input  logic [MW-1:0] mb,
    output logic          sticky_hi,
    output logic          sticky_lo
);
    localparam int CW = $clog2(MW + 1);

    function automatic logic [CW-1:0] tz_count(input logic [MW-1:0] v);
        logic found;
        tz_count = '0;
        found    = 1'b0;
        for (int i = 0; i < MW; i++) begin
            if (!found) begin
                if (v[i]) found = 1'b1;
                else      tz_count = tz_count + CW'(1);
            end
        end
    endfunction

    logic [CW:0] tz_sum;
    assign tz_sum = {1'b0, tz_count(ma)} + {1'b0, tz_count(mb)};

    // Product MSB set: MW-1 bits below the round bit; otherwise MW-2 bits.
    assign sticky_hi = tz_sum < (CW+1)'(MW - 1);
    assign sticky_lo = tz_sum < (CW+1)'(MW - 2);

endmodule

// File: rtl/fpm_exp_unit.sv
// Sign, operand classes, result kind and pre-normalization exponent.
module fpm_exp_unit
    import fpm_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] op_a,
    input  logic [EW+FW:0] op_b,
    output logic           res_sign,
    output res_kind_t      res_kind,
    output logic [EW+1:0]  exp_base
);
    localparam int EXW  = EW + 2;
    localparam int BIAS = (1 << (EW - 1)) - 1;

    function automatic op_class_t classify(input logic [EW+FW:0] w);
        if (w[EW+FW-1:FW] == '0)       classify = CLS_ZERO;
        else if (&w[EW+FW-1:FW])       classify = (w[FW-1:0] != '0) ? CLS_NAN : CLS_INF;
        else                           classify = CLS_NORM;
    endfunction

    op_class_t cls_a, cls_b;
    assign cls_a = classify(op_a);
    assign cls_b = classify(op_b);

    assign res_sign = op_a[EW+FW] ^ op_b[EW+FW];
    assign exp_base = EXW'(op_a[EW+FW-1:FW]) + EXW'(op_b[EW+FW-1:FW]) - EXW'(BIAS);

    always_comb begin
        unique case (cls_a)
            CLS_NAN:  res_kind = RES_QNAN;
            CLS_INF:  res_kind = (cls_b == CLS_ZERO || cls_b == CLS_NAN) ? RES_QNAN : RES_INF;
            CLS_ZERO: res_kind = (cls_b == CLS_INF || cls_b == CLS_NAN) ? RES_QNAN : RES_ZERO;
            CLS_NORM: begin
                unique case (cls_b)
                    CLS_NAN:  res_kind = RES_QNAN;
                    CLS_INF:  res_kind = RES_INF;
                    CLS_ZERO: res_kind = RES_ZERO;
                    CLS_NORM: res_kind = RES_NORMAL;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
    import fpm_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [EW+FW:0]   in_a,
    input  logic [EW+FW:0]   in_b,
    output logic             out_valid,
    output logic [EW+FW:0]   out_result,
    output logic             out_overflow,
    output logic             out_underflow
);
    localparam int WW   = EW + FW + 1;
    localparam int MW   = FW + 1;
    localparam int EXW  = EW + 2;
    localparam int MAXE = (1 << EW) - 1;

    // Stage 1: operand register
    logic          v_q;
    logic [WW-1:0] a_q, b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            a_q <= '0;
            b_q <= '0;
        end else begin
            v_q <= in_valid;
            a_q <= in_a;
            b_q <= in_b;
        end
    end

    // Exponent and class path
    logic          r_sign;
    res_kind_t     r_kind;
    logic [EXW-1:0] e_base;

    fpm_exp_unit #(.EW(EW), .FW(FW)) u_exp (
        .op_a     (a_q),
        .op_b     (b_q),
        .res_sign (r_sign),
        .res_kind (r_kind),
        .exp_base (e_base)
    );

    // Mantissa path
    logic [MW-1:0] man_a, man_b;
    logic [MW+1:0] p_top;
    logic          st_hi, st_lo;

    assign man_a = {1'b1, a_q[FW-1:0]};
    assign man_b = {1'b1, b_q[FW-1:0]};

    fpm_booth_array #(.MW(MW)) u_arr (
        .mcand    (man_a),
        .mplier   (man_b),
        .prod_top (p_top)
    );

    fpm_tz_sticky #(.MW(MW)) u_sticky (
        .ma        (man_a),
        .mb        (man_b),
        .sticky_hi (st_hi),
        .sticky_lo (st_lo)
    );

    // Normalize and round to nearest even
    logic           norm;
    logic [MW-1:0]  mant;
    logic           rbit, sticky, inc;
    logic [MW:0]    rsum;
    logic [EXW-1:0] e_fin;
    logic           ovf, unf;

    assign norm   = p_top[MW+1];
    assign mant   = norm ? p_top[MW+1:2] : p_top[MW:1];
    assign rbit   = norm ? p_top[1] : p_top[0];
    assign sticky = norm ? st_hi : st_lo;
    assign inc    = rbit & (sticky | mant[0]);
    assign rsum   = {1'b0, mant} + (MW+1)'(inc);
    assign e_fin  = e_base + EXW'(norm) + EXW'(rsum[MW]);
    assign ovf    = !e_fin[EXW-1] && (e_fin >= EXW'(MAXE));
    assign unf    = e_fin[EXW-1] || (e_fin == '0);

    // Output formatting by result kind
    logic [WW-1:0] res_d;
    logic          ovf_d, unf_d;

    always_comb begin
        ovf_d = 1'b0;
        unf_d = 1'b0;
        unique case (r_kind)
            RES_QNAN:   res_d = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
            RES_INF:    res_d = {r_sign, {EW{1'b1}}, {FW{1'b0}}};
            RES_ZERO:   res_d = {r_sign, {(WW-1){1'b0}}};
            RES_NORMAL: begin
                if (ovf) begin
                    ovf_d = 1'b1;
                    res_d = {r_sign, {EW{1'b1}}, {FW{1'b0}}};
                end else if (unf) begin
                    unf_d = 1'b1;
                    res_d = {r_sign, {(WW-1){1'b0}}};
                end else begin
                    res_d = {r_sign, e_fin[EW-1:0], rsum[FW-1:0]};
                end
            end
        endcase
    end

    // Stage 2: result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_overflow  <= 1'b0;
            out_underflow <= 1'b0;
        end else begin
            out_valid     <= v_q;
            out_result    <= res_d;
            out_overflow  <= ovf_d;
            out_underflow <= unf_d;
        end
    end

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_overflow,
    input logic        out_underflow
);

    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_overflow, out_underflow}));

    assert_overflow_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> out_result[30:0] == 31'h7F800000);

    assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_underflow |-> out_result[30:0] == 31'h0);

    assert_sign_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[30:22] != 9'h1FF) |->
        out_result[31] == ($past(in_a[31], 2) ^ $past(in_b[31], 2)));

    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[30:23] == 8'h00 && in_b[30:23] != 8'hFF) |=> ##1
        (out_result[30:0] == 31'h0 && !out_overflow && !out_underflow));

    assert_nan_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[30:23] == 8'hFF && in_a[22:0] != 23'h0) |=> ##1
        (out_result == 32'h7FC00000 && !out_overflow && !out_underflow));

    assert_nan_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_b[30:23] == 8'hFF && in_b[22:0] != 23'h0) |=> ##1
        (out_result == 32'h7FC00000));

endmodule

bind fpm_mul fpm_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_a          (in_a),
    .in_b          (in_b),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_overflow  (out_overflow),
    .out_underflow (out_underflow)
);

// File: tb/tb_fpm_mul.sv
module tb_fpm_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_overflow;
    logic        out_underflow;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    fpm_mul dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_a          (in_a),
        .in_b          (in_b),
        .out_valid     (out_valid),
        .out_result    (out_result),
        .out_overflow  (out_overflow),
        .out_underflow (out_underflow)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Behavioural model: exact product, remainder-based rounding.
    task automatic ref_mul(input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] r, output logic o, output logic u);
        int ea, eb, e, sh;
        logic s, nan_a, nan_b, inf_a, inf_b, zer_a, zer_b;
        logic [63:0] p, m, rem, half;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        s  = a[31] ^ b[31];
        o  = 1'b0;
        u  = 1'b0;
        nan_a = (ea == 255) && (a[22:0] != 0);
        nan_b = (eb == 255) && (b[22:0] != 0);
        inf_a = (ea == 255) && (a[22:0] == 0);
        inf_b = (eb == 255) && (b[22:0] == 0);
        zer_a = (ea == 0);
        zer_b = (eb == 0);
        if (nan_a || nan_b || (inf_a && zer_b) || (inf_b && zer_a)) begin
            r = 32'h7FC00000;
        end else if (inf_a || inf_b) begin
            r = {s, 8'hFF, 23'h0};
        end else if (zer_a || zer_b) begin
            r = {s, 31'h0};
        end else begin
            p = {40'h0, 1'b1, a[22:0]} * {40'h0, 1'b1, b[22:0]};
            e = ea + eb - 127;
            if (p[47]) begin sh = 24; e = e + 1; end
            else sh = 23;
            m    = p >> sh;
            rem  = p & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            if (rem > half || (rem == half && m[0])) m = m + 64'd1;
            if (m == (64'd1 << 24)) begin m = 64'd1 << 23; e = e + 1; end
            if (e >= 255) begin o = 1'b1; r = {s, 8'hFF, 23'h0}; end
            else if (e <= 0) begin u = 1'b1; r = {s, 31'h0}; end
            else r = {s, e[7:0], m[22:0]};
        end
    endtask

    // One cycle: compare the outputs due now, then drive the next pair.
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
        logic [34:0] e;
        string       t;
        logic [31:0] r;
        logic        o, u;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk("R7", "valid", {31'h0, out_valid}, {31'h0, e[34]});
        if (e[34]) begin
            chk(t, "result", out_result, e[31:0]);
            chk(t, "flags", {30'h0, out_overflow, out_underflow}, {30'h0, e[33:32]});
            chk("R10", "flag_pair", {31'h0, out_overflow & out_underflow}, 32'h0);
        end
        ref_mul(a, b, r, o, u);
        exp_q.push_back({v, o, u, r});
        tag_q.push_back(tag);
        in_valid = v;
        in_a     = a;
        in_b     = b;
    endtask

    function automatic logic [31:0] rnd32();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] rnd_op(input bit mid);
        logic [31:0] x;
        logic [7:0]  ex;
        x  = rnd32();
        ex = mid ? 8'(96 + (x[31:24] % 64)) : 8'(1 + (x[31:24] % 254));
        return {x[23], ex, x[22:0]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset_valid", {31'h0, out_valid}, 32'h0);
        chk("R9", "reset_result", out_result, 32'h0);
        chk("R9", "reset_flags", {30'h0, out_overflow, out_underflow}, 32'h0);
        rst_n = 1'b1;
        exp_q.push_back(35'h0); tag_q.push_back("R9");
        exp_q.push_back(35'h0); tag_q.push_back("R9");

        step(1, 32'h3F800000, 32'h3F800000, "R1");
        step(1, 32'h40000000, 32'h40400000, "R1");
        step(1, 32'h3FC00000, 32'h3FC00000, "R1");
        step(1, 32'h3F800001, 32'h3FC00000, "R1");
        step(1, 32'h40490FDB, 32'h402DF854, "R1");
        step(1, 32'hBF800000, 32'h40000000, "R2");
        step(1, 32'hC0400000, 32'hC0000000, "R2");
        step(1, 32'h7F000000, 32'h40000000, "R3");
        step(1, 32'hFF000000, 32'h7F000000, "R3");
        step(1, 32'h00800000, 32'h00800000, "R4");
        step(1, 32'h20800000, 32'h9F000000, "R4");
        step(1, 32'h20800000, 32'h1F800000, "R4");
        step(1, 32'h00000000, 32'h40000000, "R5");
        step(1, 32'h80000000, 32'h3F800000, "R5");
        step(1, 32'h00400000, 32'h7F000000, "R5");
        step(1, 32'h3F800000, 32'h80000001, "R5");
        step(1, 32'h7F800000, 32'h40000000, "R6");
        step(1, 32'hFF800000, 32'h3F800000, "R6");
        step(1, 32'h7F800000, 32'h00000000, "R6");
        step(1, 32'h7FC00001, 32'h3F800000, "R6");
        step(1, 32'h3F800000, 32'hFF800001, "R6");
        step(1, 32'h00000000, 32'hFF800000, "R6");
        step(1, 32'h3FB504F3, 32'h3FB504F3, "R8");
        step(1, 32'h7F3504F3, 32'h3FB504F3, "R8");
        step(0, 32'h3F800000, 32'h3F800000, "R7");
        step(1, 32'h40400000, 32'h40400000, "R7");
        step(0, 32'h0, 32'h0, "R7");
        step(0, 32'h0, 32'h0, "R7");
        step(1, 32'hC1200000, 32'h3DCCCCCD, "R7");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            x = rnd32();
            step(x[1:0] != 2'b00, rnd_op(1), rnd_op(1), "R1");
        end
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            x = rnd32();
            step(x[2:0] != 3'b000, rnd_op(0), rnd_op(0), "R1");
        end
        step(0, 32'h0, 32'h0, "R7");
        step(0, 32'h0, 32'h0, "R7");
        step(0, 32'h0, 32'h0, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule